// File: doc/BRIEF.md
# Overcurrent Hiccup Retry Controller

This block supervises the overcurrent behaviour of a multiphase buck regulator. On every clock it compares a digitized average-current code with a fixed trip code. When the code goes above the trip code while the converter is regulating, the block turns off every upper and lower gate, releases the auxiliary PWM pin to high impedance and drops power-good. It then waits a fixed number of timer ticks, which stands for a 12 ms shutdown.

When the wait ends and the converter is still enabled, the block asks for a fresh soft-start. If the fault is still present, the next trip starts another wait. This hiccup loop has no retry limit. It ends only when the current falls back under the trip code or when enable is removed. Removing enable at any moment returns the block to idle, with the gates off and the wait count cleared.

The soft-start ramp and the current measurement belong to neighbouring blocks. This block only raises a soft-start request and receives a done flag in return.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, the outputs are as follows: all gate enables are 0, `aux_hiz` is 1, and `pgood` and `ss_req` are 0.
- R2: When `en` is high in idle, the next cycle shows soft-start. In soft-start `ss_req` is 1, every `ugate_en`/`lgate_en` bit is 1 and `aux_hiz` is 0.
- R3: When `ss_done` is high during soft-start and there is no trip, the next cycle shows run. In run `pgood` is 1, `ss_req` is 0 and the gates stay enabled.
- R4: A trip is detected only when `iavg_code` is strictly greater than `OCP_REF`. A code equal to `OCP_REF` has no effect.
- R5: A trip sampled in soft-start or run gives, in the next cycle, all gate enables at 0, `aux_hiz` at 1, and `pgood` and `ss_req` at 0.
- R6: The shutdown lasts exactly `HOLD_TICKS` cycles in which `tick` is high. Cycles without `tick` do not advance it.
- R7: The edge that samples the last hold tick moves the block to soft-start if `en` is high at that edge, and to idle if it is not.
- R8: A trip during a retry soft-start starts a new full shutdown. The number of retries has no limit.
- R9: `en` low at any edge sends the block to idle in the next cycle and clears the hold count. A later trip then waits the full `HOLD_TICKS`.
- R10: `pgood` rises only on the cycle after `ss_done` is sampled in soft-start with no trip. It stays 0 for the whole of a retry soft-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable |
| iavg_code | input | CODE_W | Digitized average phase current |
| ss_done | input | 1 | Soft-start ramp complete |
| tick | input | 1 | One-cycle timebase pulse for the shutdown count |
| ugate_en | output | NPH | Upper gate enable, one bit per phase |
| lgate_en | output | NPH | Lower gate enable, one bit per phase |
| aux_hiz | output | 1 | 1 puts the auxiliary PWM pin in high impedance |
| pgood | output | 1 | Power-good |
| ss_req | output | 1 | Soft-start request to the ramp generator |

## Verification
Directed sequences cover several cases. A current code equal to the trip code is set against one a single step above it, which separates a strict compare from an inclusive one. Hold phases mix tick and idle cycles, so an off-by-one count or a count of clock cycles instead of ticks shows up. A run that drops enable partway through a hold and then trips again detects a hold count that was not cleared. Random stimulus is then spread around the trip code with tick, done flag, enable and reset all varying, so that repeated trips during retries and the order of the transition checks are compared with a bench reference model on every cycle.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SOFT = 2'd1,
        ST_RUN  = 2'd2,
        ST_HOLD = 2'd3
    } ocp_state_t;

    typedef struct packed {
        logic gates_on;
        logic aux_hiz;
        logic pg;
        logic ssr;
    } drive_t;

    function automatic drive_t decode_drive(ocp_state_t s);
        drive_t d;
        d.gates_on = (s == ST_SOFT) || (s == ST_RUN);
        d.aux_hiz  = !d.gates_on;
        d.pg       = (s == ST_RUN);
        d.ssr      = (s == ST_SOFT);
        return d;
    endfunction

    function automatic int cnt_width(int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ocp_compare.sv
module ocp_compare #(
    parameter int CODE_W  = 10,
    parameter int OCP_REF = 500
) (
    input  logic [CODE_W-1:0] iavg_code,
    output logic              over
);
    localparam logic [CODE_W-1:0] REF_C = CODE_W'(OCP_REF);

    always_comb begin
        over = (iavg_code > REF_C);
    end
endmodule

// File: rtl/ocp_hold_timer.sv
module ocp_hold_timer #(
    parameter int HOLD_TICKS = 12000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = ocp_pkg::cnt_width(HOLD_TICKS);
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    logic [CW-1:0] cnt;

    always_comb begin
        done = run && tick && (cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);  // R6
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);  // R9
endmodule

// File: rtl/ocp_fsm.sv
module ocp_fsm
    import ocp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       over,
    input  logic       ss_done,
    input  logic       hold_done,
    output ocp_state_t state
);
    ocp_state_t nxt;

    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_SOFT;
                ST_SOFT: begin
                    if (over)         nxt = ST_HOLD;
                    else if (ss_done) nxt = ST_RUN;
                end
                ST_RUN:  if (over) nxt = ST_HOLD;
                ST_HOLD: if (hold_done) nxt = ST_SOFT;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    AST_RETRY_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && hold_done && en) |=> state == ST_SOFT);  // R7
    AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !hold_done && en) |=> state == ST_HOLD);  // R6
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl
    import ocp_pkg::*;
#(
    parameter int NPH        = 4,
    parameter int CODE_W     = 10,
    parameter int OCP_REF    = 500,
    parameter int HOLD_TICKS = 12000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [CODE_W-1:0] iavg_code,
    input  logic              ss_done,
    input  logic              tick,
    output logic [NPH-1:0]    ugate_en,
    output logic [NPH-1:0]    lgate_en,
    output logic              aux_hiz,
    output logic              pgood,
    output logic              ss_req
);
    ocp_state_t state;
    drive_t     drv;
    logic       over;
    logic       hold_done;
    logic       hold_run;

    ocp_compare #(.CODE_W(CODE_W), .OCP_REF(OCP_REF)) u_cmp (
        .iavg_code (iavg_code),
        .over      (over)
    );

    ocp_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .run  (hold_run),
        .tick (tick),
        .done (hold_done)
    );

    ocp_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .over      (over),
        .ss_done   (ss_done),
        .hold_done (hold_done),
        .state     (state)
    );

    always_comb begin
        hold_run = (state == ST_HOLD);
        drv      = decode_drive(state);
        aux_hiz  = drv.aux_hiz;
        pgood    = drv.pg;
        ss_req   = drv.ssr;
    end

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        assign ugate_en[p] = drv.gates_on;
        assign lgate_en[p] = drv.gates_on;
    end

    AST_TRIP_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
        (en && over && (ss_req || pgood)) |=>
        (ugate_en == '0 && lgate_en == '0 && aux_hiz && !pgood && !ss_req));  // R5
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> (ugate_en == '0 && lgate_en == '0 && !pgood && !ss_req));  // R9
    AST_PGOOD_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(pgood) |-> ($past(ss_done) && $past(ss_req)));  // R10
    AST_NO_TRIP_AT_REF: assert property (@(posedge clk) disable iff (rst)
        (pgood && en && !over) |=> pgood);  // R4
endmodule

// File: tb/sim_ocp_hiccup_ctrl.sv
module sim_ocp_hiccup_ctrl;
    localparam int NPH  = 4;
    localparam int W    = 10;
    localparam int REF  = 500;
    localparam int HOLD = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst, en, ss_done, tick;
    logic [W-1:0]   iavg_code;
    logic [NPH-1:0] ugate_en, lgate_en;
    logic           aux_hiz, pgood, ss_req;

    int nchk = 0;
    int nerr = 0;
    int ms = 0;   // 0 idle, 1 soft-start, 2 run, 3 hold
    int mc = 0;

    ocp_hiccup_ctrl #(.NPH(NPH), .CODE_W(W), .OCP_REF(REF), .HOLD_TICKS(HOLD)) u0 (
        .clk(clk), .rst(rst), .en(en), .iavg_code(iavg_code), .ss_done(ss_done),
        .tick(tick), .ugate_en(ugate_en), .lgate_en(lgate_en), .aux_hiz(aux_hiz),
        .pgood(pgood), .ss_req(ss_req)
    );

    function automatic logic [2*NPH+2:0] expect_of(int s);
        logic on;
        on = (s == 1) || (s == 2);
        return {{NPH{on}}, {NPH{on}}, !on, s == 2, s == 1};
    endfunction

    task automatic model_step();
        bit oc;
        oc = (int'(iavg_code) > REF);
        if (rst) begin
            ms = 0; mc = 0;
        end else if (!en) begin
            ms = 0; mc = 0;
        end else begin
            case (ms)
                0: ms = 1;
                1: if (oc) begin ms = 3; mc = 0; end else if (ss_done) ms = 2;
                2: if (oc) begin ms = 3; mc = 0; end
                default: begin
                    if (tick) begin
                        if (mc == HOLD - 1) begin ms = 1; mc = 0; end
                        else mc = mc + 1;
                    end
                end
            endcase
        end
    endtask

    task automatic step(bit r, bit e, int code, bit sd, bit tk, string tag);
        logic [2*NPH+2:0] act, exp;
        rst = r; en = e; iavg_code = code[W-1:0]; ss_done = sd; tick = tk;
        @(posedge clk);
        model_step();
        @(negedge clk);
        act = {ugate_en, lgate_en, aux_hiz, pgood, ss_req};
        exp = expect_of(ms);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: outputs actual=%b expected=%b (model state %0d)", tag, act, exp, ms);
        end
    endtask

    task automatic hold_ticks(int n, bit e, int code, string tag);
        for (int i = 0; i < n; i++) begin
            step(0, e, code, 0, 0, tag);
            step(0, e, code, 0, 1, tag);
        end
    endtask

    initial begin
        #2000000;
        nerr++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1; en = 0; ss_done = 0; tick = 0; iavg_code = '0;
        @(negedge clk);
        step(1, 1, REF + 3, 1, 1, "R1 reset held");
        step(1, 0, 0, 0, 0, "R1 reset held");
        step(0, 0, 0, 0, 0, "R1 after reset");
        step(0, 1, 0, 0, 0, "R2 enable to soft-start");
        step(0, 1, 0, 1, 0, "R3 done to run");
        step(0, 1, REF, 0, 0, "R4 code equal to ref");
        step(0, 1, REF, 0, 1, "R4 code equal to ref");
        step(0, 1, REF + 1, 0, 0, "R5 trip one above ref");
        hold_ticks(HOLD - 1, 1, REF + 1, "R6 hold counting ticks");
        step(0, 1, REF + 1, 0, 0, "R6 no tick no advance");
        step(0, 1, REF + 1, 0, 1, "R7 retry after last tick");
        step(0, 1, REF + 1, 0, 0, "R8 trip during retry");
        hold_ticks(HOLD - 1, 1, REF + 9, "R8 second hold");
        step(0, 1, 0, 0, 1, "R8 second retry");
        step(0, 1, 0, 0, 0, "R10 pgood low in retry");
        step(0, 1, 0, 1, 0, "R10 pgood after done");
        step(0, 1, REF + 2, 0, 0, "R9 trip");
        hold_ticks(3, 1, REF + 2, "R9 partial hold");
        step(0, 0, REF + 2, 0, 1, "R9 disable mid-hold");
        step(0, 1, 0, 0, 0, "R9 re-enable");
        step(0, 1, REF + 2, 0, 0, "R9 trip again");
        hold_ticks(HOLD - 1, 1, REF + 2, "R9 full hold after clear");
        step(0, 1, REF + 2, 0, 1, "R9 full hold after clear");
        step(0, 1, REF + 4, 0, 0, "R8 trip");
        hold_ticks(HOLD - 1, 1, REF + 4, "R7 hold");
        step(0, 0, 0, 0, 1, "R7 disabled at end of hold");
        for (int i = 0; i < 4000; i++) begin
            int code;
            int sel;
            sel = $urandom_range(0, 9);
            if (sel == 0)      code = REF + 1;
            else if (sel == 1) code = REF;
            else if (sel == 2) code = $urandom_range(0, (1 << W) - 1);
            else               code = $urandom_range(0, REF - 1);
            step($urandom_range(0, 199) == 0, $urandom_range(0, 39) != 0, code,
                 $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
                 "random R4 R5 R6 R8 R10");
        end
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule